// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block turns a raster-ordered stream of output pixels into byte write addresses inside a destination framebuffer. The pixel source walks the image left to right, top to bottom. For every pixel the generator presents the address where that pixel must land once the image is rotated by 0, 90, 180 or 270 degrees clockwise. The image can be stored either as plain rows or as 8x8 tiles.

A frame begins with a `start` pulse while the block is idle. At that pulse the base address, the size fields (each holding the dimension minus one), the rotation code, the tiling switch and the pixel format are all captured. From then on the block holds `addr_valid` high and presents one address at a time. Each `adv` pulse consumes the current address and moves to the next pixel. Flags mark the first and the last pixel of the frame. A geometry that cannot be tiled, or that is too tall, is refused: the block raises `cfg_err` and produces no addresses.

Top module: `rot_tile_addr_gen`

## Requirements
- R1: `width_m1` (9 bits) and `height_m1` (10 bits) carry the dimension minus one, and both dimensions range from 1 to 512. A `height_m1` above 511 sets `cfg_err` and produces no addresses. Width 512 with height 1 is a legal frame.
- R2: With rotation code 0 and tiling off, source pixel (x, y) is written at base + (y*W + x)*bpp.
- R3: With rotation code 1 (90 degrees clockwise), the stored image is H wide and W tall, and source (x, y) goes to column H-1-y, row x.
- R4: With rotation code 2 (180 degrees, no mirroring), source (x, y) goes to column W-1-x, row H-1-y, and the stored image is W wide.
- R5: With rotation code 3 (270 degrees clockwise), the stored image is H wide, and source (x, y) goes to column y, row W-1-x.
- R6: With tiling on, a destination (c, r) in a stored image S wide has pixel index ((r/8)*(S/8) + c/8)*64 + (r%8)*8 + c%8.
- R7: A tiling request in which W or H is not a multiple of 8 sets `cfg_err` and produces no addresses. `cfg_err` holds until the next accepted `start`, which recomputes it.
- R8: `pix_fmt` selects the bytes per pixel: 0 gives 4, 1 gives 3, and 2 or 3 give 2.
- R9: `addr_valid` is high for the whole of a frame. The address holds until `adv` is seen. Each `adv` steps x first and moves to the next row after x = W-1.
- R10: `sof` is high with the first pixel's address and `eof` with the last. The `adv` that consumes the last pixel returns the block to idle on the next cycle.
- R11: A `start` during a frame is ignored, and changes to the configuration inputs during a frame do not alter its addresses.
- R12: After reset the block is idle, with `addr_valid`, `sof`, `eof` and `cfg_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (honoured only while idle) |
| base_addr | input | 32 | Framebuffer byte base address |
| width_m1 | input | 9 | Output width minus one |
| height_m1 | input | 10 | Output height minus one |
| rot | input | 2 | Rotation code: 0, 90, 180, 270 degrees clockwise |
| tile_en | input | 1 | Store as 8x8 tiles |
| pix_fmt | input | 2 | Pixel format code selecting bytes per pixel |
| adv | input | 1 | Current address consumed, move to next pixel |
| addr | output | 32 | Byte address of the current pixel |
| addr_valid | output | 1 | A frame is running and `addr` is meaningful |
| sof | output | 1 | Current pixel is the first of the frame |
| eof | output | 1 | Current pixel is the last of the frame |
| cfg_err | output | 1 | Last start request was refused |

## Verification
Several properties are checked on every cycle. The address must stay stable while `adv` is low. A frame must never stop before `eof`. An accepted legal start must be followed directly by `sof`. The block must fall idle after the final `adv`. `cfg_err` must never overlap a running frame and must change only at an accepted start. The address arithmetic itself cannot be captured by these properties, so only the bench scenarios show it: every pixel of each rotation, the tiled and untiled layouts, the three pixel sizes, the 512-pixel edge, a single-pixel frame, and the refusals. The bench reference model compares its own result against each of these on every clock.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  // pixel format code -> bytes per pixel (R8)
  function automatic logic [2:0] bytes_per_pix(input logic [1:0] fmt);
    case (fmt)
      2'd0:    return 3'd4;
      2'd1:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/agc_raster.sv
module agc_raster #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] w_m1,
  input  logic [CW-1:0] h_m1,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic          first,
  output logic          last
);

  logic row_end;

  assign row_end = (x == w_m1);
  assign first   = (x == '0) && (y == '0);
  assign last    = row_end && (y == h_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (load) begin
      x <= '0;
      y <= '0;
    end else if (step && !last) begin
      if (row_end) begin
        x <= '0;
        y <= y + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end

endmodule

// File: rtl/agc_rotate.sv
module agc_rotate
  import agc_pkg::*;
#(
  parameter int CW = 9
) (
  input  rot_e          rot,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] w_m1,
  input  logic [CW-1:0] h_m1,
  output logic [CW-1:0] dx,
  output logic [CW-1:0] dy,
  output logic [CW-1:0] sw_m1
);

  always_comb begin
    unique case (rot)
      ROT_90: begin          // R3
        dx    = h_m1 - y;
        dy    = x;
        sw_m1 = h_m1;
      end
      ROT_180: begin         // R4
        dx    = w_m1 - x;
        dy    = h_m1 - y;
        sw_m1 = w_m1;
      end
      ROT_270: begin         // R5
        dx    = y;
        dy    = w_m1 - x;
        sw_m1 = h_m1;
      end
      default: begin         // R2
        dx    = x;
        dy    = y;
        sw_m1 = w_m1;
      end
    endcase
  end

endmodule

// File: rtl/agc_layout.sv
module agc_layout #(
  parameter int CW      = 9,
  parameter int TILE_LG = 3,
  localparam int IDXW   = 2 * CW,
  localparam int TW     = IDXW - 2 * TILE_LG
) (
  input  logic            tile,
  input  logic [CW-1:0]   dx,
  input  logic [CW-1:0]   dy,
  input  logic [CW-1:0]   sw_m1,
  output logic [IDXW-1:0] idx
);

  // plain rows: dy * stored_width + dx
  function automatic logic [IDXW-1:0] row_index(
    input logic [CW-1:0] c, input logic [CW-1:0] r, input logic [CW:0] sw);
    return IDXW'(r) * IDXW'(sw) + IDXW'(c);
  endfunction

  // 8x8 tiles, row-major within and across tiles (R6)
  function automatic logic [IDXW-1:0] tile_index(
    input logic [CW-1:0] c, input logic [CW-1:0] r, input logic [CW:0] sw);
    logic [TW-1:0] tnum;
    tnum = TW'(r >> TILE_LG) * TW'(sw >> TILE_LG) + TW'(c >> TILE_LG);
    return {tnum, r[TILE_LG-1:0], c[TILE_LG-1:0]};
  endfunction

  logic [CW:0] sw;
  assign sw  = {1'b0, sw_m1} + 1'b1;
  assign idx = tile ? tile_index(dx, dy, sw) : row_index(dx, dy, sw);

endmodule

// File: rtl/rot_tile_addr_gen.sv
module rot_tile_addr_gen
  import agc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int WFLD    = 9,
  parameter int HFLD    = 10,
  parameter int TILE_LG = 3,
  localparam int CW     = WFLD,
  localparam int IDXW   = 2 * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  input  logic [WFLD-1:0] width_m1,
  input  logic [HFLD-1:0] height_m1,
  input  logic [1:0]      rot,
  input  logic            tile_en,
  input  logic [1:0]      pix_fmt,
  input  logic            adv,
  output logic [AW-1:0]   addr,
  output logic            addr_valid,
  output logic            sof,
  output logic            eof,
  output logic            cfg_err
);

  state_e          state;
  logic [AW-1:0]   base_q;
  logic [CW-1:0]   w_m1_q, h_m1_q;
  rot_e            rot_q;
  logic            tile_q;
  logic [1:0]      fmt_q;

  // named internal events (observed by the checker)
  logic            start_acc;
  logic            cfg_bad;
  logic            step;
  logic            frame_done;

  logic [CW-1:0]   x, y, dx, dy, sw_m1;
  logic            first, last;
  logic [IDXW-1:0] idx;

  // shift-and-add scaling by 2, 3 or 4 bytes (R8)
  function automatic logic [AW-1:0] scale_idx(input logic [IDXW-1:0] i,
                                                input logic [1:0] fmt);
    logic [AW-1:0] w;
    w = AW'(i);
    case (bytes_per_pix(fmt))
      3'd4:    return w << 2;
      3'd3:    return (w << 1) + w;
      default: return w << 1;
    endcase
  endfunction

  assign start_acc  = start && (state == ST_IDLE);
  assign cfg_bad    = (|height_m1[HFLD-1:CW]) ||
                      (tile_en && !((&width_m1[TILE_LG-1:0]) &&
                                    (&height_m1[TILE_LG-1:0])));
  assign step       = (state == ST_RUN) && adv;
  assign frame_done = step && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      w_m1_q  <= '0;
      h_m1_q  <= '0;
      rot_q   <= ROT_0;
      tile_q  <= 1'b0;
      fmt_q   <= 2'd0;
      cfg_err <= 1'b0;
    end else if (start_acc) begin
      base_q  <= base_addr;
      w_m1_q  <= width_m1;
      h_m1_q  <= height_m1[CW-1:0];
      rot_q   <= rot_e'(rot);
      tile_q  <= tile_en;
      fmt_q   <= pix_fmt;
      cfg_err <= cfg_bad;
      state   <= cfg_bad ? ST_IDLE : ST_RUN;
    end else if (frame_done) begin
      state   <= ST_IDLE;
    end
  end

  agc_raster #(.CW(CW)) u_raster (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_acc),
    .step  (step),
    .w_m1  (w_m1_q),
    .h_m1  (h_m1_q),
    .x     (x),
    .y     (y),
    .first (first),
    .last  (last)
  );

  agc_rotate #(.CW(CW)) u_rotate (
    .rot   (rot_q),
    .x     (x),
    .y     (y),
    .w_m1  (w_m1_q),
    .h_m1  (h_m1_q),
    .dx    (dx),
    .dy    (dy),
    .sw_m1 (sw_m1)
  );

  agc_layout #(.CW(CW), .TILE_LG(TILE_LG)) u_layout (
    .tile  (tile_q),
    .dx    (dx),
    .dy    (dy),
    .sw_m1 (sw_m1),
    .idx   (idx)
  );

  assign addr       = base_q + scale_idx(idx, fmt_q);
  assign addr_valid = (state == ST_RUN);
  assign sof        = addr_valid && first;
  assign eof        = addr_valid && last;

endmodule

// File: rtl/agc_sva.sv
module agc_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv,
  input logic [AW-1:0] addr,
  input logic          addr_valid,
  input logic          sof,
  input logic          eof,
  input logic          cfg_err,
  input logic          start_acc,
  input logic          cfg_bad,
  input logic          frame_done
);

  p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !adv |=> addr_valid && $stable(addr));

  p_no_early_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !eof |=> addr_valid);

  p_sof_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && !cfg_bad |=> addr_valid && sof);

  p_idle_after_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !addr_valid);

  p_sof_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && adv && sof |=> !sof);

  p_err_no_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !addr_valid);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> $stable(cfg_err));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !start_acc);

endmodule

bind rot_tile_addr_gen agc_sva #(.AW(AW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .adv        (adv),
  .addr       (addr),
  .addr_valid (addr_valid),
  .sof        (sof),
  .eof        (eof),
  .cfg_err    (cfg_err),
  .start_acc  (start_acc),
  .cfg_bad    (cfg_bad),
  .frame_done (frame_done)
);

// File: tb/rot_tile_addr_gen_tb.sv
`timescale 1ns/1ps
module rot_tile_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [8:0]  width_m1 = '0;
  logic [9:0]  height_m1 = '0;
  logic [1:0]  rot = '0;
  logic        tile_en = 1'b0;
  logic [1:0]  pix_fmt = '0;
  logic        adv = 1'b0;
  logic [31:0] addr;
  logic        addr_valid, sof, eof, cfg_err;

  always #4 clk = ~clk;  // 125 MHz

  rot_tile_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .width_m1(width_m1), .height_m1(height_m1), .rot(rot), .tile_en(tile_en),
    .pix_fmt(pix_fmt), .adv(adv), .addr(addr), .addr_valid(addr_valid),
    .sof(sof), .eof(eof), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  bit stutter = 0;
  string sc_req = "R2";
  string err_req = "R7";

  // reference model state
  bit          m_run = 0, m_err = 0;
  int          m_x, m_y, m_w, m_h, m_rot, m_bpp;
  bit          m_tile;
  longint      m_base;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint exp_addr(int x, int y);
    int c, r, s, idx;
    case (m_rot)
      1:       begin c = m_h - 1 - y; r = x;           s = m_h; end
      2:       begin c = m_w - 1 - x; r = m_h - 1 - y; s = m_w; end
      3:       begin c = y;           r = m_w - 1 - x; s = m_h; end
      default: begin c = x;           r = y;           s = m_w; end
    endcase
    if (m_tile) idx = ((r / 8) * (s / 8) + c / 8) * 64 + (r % 8) * 8 + (c % 8);
    else        idx = r * s + c;
    return (m_base + longint'(idx) * m_bpp) & 64'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_run = 0; m_err = 0; m_x = 0; m_y = 0;
    end else if (m_run) begin
      if (adv) begin
        if (m_x == m_w - 1 && m_y == m_h - 1) m_run = 0;
        else if (m_x == m_w - 1) begin m_x = 0; m_y++; end
        else m_x++;
      end
    end else if (start) begin
      m_base = base_addr; m_w = width_m1 + 1; m_h = height_m1 + 1;
      m_rot = rot; m_tile = tile_en;
      m_bpp = (pix_fmt == 0) ? 4 : (pix_fmt == 1) ? 3 : 2;
      m_err = (m_h > 512) || (m_tile && ((m_w % 8) != 0 || (m_h % 8) != 0));
      m_run = !m_err; m_x = 0; m_y = 0;
    end
  end

  // adv pattern driven away from the active edge
  always @(negedge clk) adv <= stutter ? ((cyc % 3) != 1) : 1'b1;

  // compare against model every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R9 addr_valid", addr_valid, m_run);
      chk({err_req, " cfg_err"}, cfg_err, m_err);
      if (m_run) begin
        chk({sc_req, " addr"}, addr, exp_addr(m_x, m_y));
        chk("R10 sof", sof, (m_x == 0 && m_y == 0));
        chk("R10 eof", eof, (m_x == m_w - 1 && m_y == m_h - 1));
      end
    end
  end

  task automatic run(input string req, input int b, input int wm1, input int hm1,
                     input int r, input bit t, input int f, input bit mess);
    @(negedge clk);
    sc_req = req;
    base_addr = b; width_m1 = wm1[8:0]; height_m1 = hm1[9:0];
    rot = r[1:0]; tile_en = t; pix_fmt = f[1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_run) begin
      @(negedge clk);
      if (mess && m_run) begin  // R11: disturb inputs mid-frame
        base_addr = ~base_addr; rot = rot + 2'd1; tile_en = ~tile_en;
        width_m1 = width_m1 ^ 9'h3; start = (cyc % 5) == 0;
      end
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 addr_valid", addr_valid, 0);
    chk("R12 sof", sof, 0);
    chk("R12 eof", eof, 0);
    chk("R12 cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R2",  32'h1000, 4, 2, 0, 0, 0, 0);
    run("R3",  32'h2000, 4, 2, 1, 0, 0, 0);
    run("R4",  32'h3000, 4, 2, 2, 0, 0, 0);
    run("R5",  32'h4000, 4, 2, 3, 0, 0, 0);
    stutter = 1;
    run("R6 R2", 32'h8000, 15, 7, 0, 1, 0, 0);
    run("R6 R3", 32'h9000, 15, 7, 1, 1, 2, 0);
    run("R6 R4", 32'hA000, 7, 15, 2, 1, 1, 0);
    run("R6 R5", 32'hB000, 15, 7, 3, 1, 3, 0);
    run("R8 fmt1", 32'h100, 6, 3, 0, 0, 1, 0);
    run("R8 fmt3", 32'h100, 6, 3, 2, 0, 3, 0);
    run("R11", 32'hC000, 5, 4, 1, 0, 0, 1);
    stutter = 0;
    run("R1 wide", 32'h10000, 511, 0, 1, 0, 0, 0);
    run("R10 single", 32'h44, 0, 0, 3, 0, 2, 0);

    // R7: tiling with width not multiple of 8
    err_req = "R7";
    run("R7", 32'h500, 11, 7, 0, 1, 0, 0);
    chk("R7 refused", {cfg_err, addr_valid}, 2'b10);
    // R7: error clears on next good start
    run("R7 clear", 32'h600, 7, 7, 2, 1, 0, 0);
    chk("R7 cleared", cfg_err, 0);
    // R1: height 513 refused
    err_req = "R1";
    run("R1", 32'h700, 3, 512, 0, 0, 0, 0);
    chk("R1 tall refused", {cfg_err, addr_valid}, 2'b10);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule